// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine walks a ring of transmit descriptors that host software fills in. For each descriptor the host has handed over, it fetches the frame from packet RAM and sends it as 16-bit beats on a streaming source with valid/ready flow control. When the frame is finished it gives the descriptor back to the host. Each descriptor supplies an ownership bit, a pad request, a timestamp request, a 16-bit frame identifier, a byte offset into packet RAM, a byte length and a 32-bit destination port mask. The descriptor table and the packet RAM both sit outside the block. The engine reads the entry its index port selects and writes status back through a one-cycle writeback strobe. It reads packet RAM through an asynchronous-read word port.

Two sticky status flags report progress: a drained flag and a fault flag. The host clears each by pulsing a clear input. Two level interrupts, frame sent and frame fault, each have a pending bit, an acknowledge input and a mask input. If the sink reports an error partway through a frame, the frame stops at once, the failing descriptor is flagged, and the index stays on that descriptor until the host clears the fault. Pulling the enable input low sends the index back to entry 0.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset, out_valid, desc_wb_en, both status flags and both interrupts are 0, and desc_idx is 0.
- R2: While tx_en is 1, the engine starts a frame only on the entry at desc_idx whose desc_ready is 1. Entries are visited in ascending order and the index wraps from 7 to 0. While the current entry's ready bit is 0, the engine waits on that entry.
- R3: Data beat k of a frame carries bytes offset+2k and offset+2k+1 of packet RAM. ram_addr is that byte address divided by 4. The low half of the 32-bit word (bits 15:0) is used when bit 1 of the byte address is 0, and bits 31:16 otherwise. A beat not accepted (out_ready low) is held unchanged.
- R4: When the final beat of a frame is accepted, the engine pulses desc_wb_en with desc_wb_err=0, which tells the host to clear that entry's ready bit. desc_idx then advances by one.
- R5: When desc_pad_en is 1 and the length is below 60 bytes, the frame is sent as 60 bytes, and every byte at or past the original length is zero. Otherwise exactly the length is sent. The length is even and nonzero.
- R6: When desc_ts_en is 1, one extra beat follows the data. On that beat out_oob is 1 and out_data carries the frame identifier. out_last marks that beat, or the final data beat when no tag is sent.
- R7: While a frame is being sent, out_pmask shows the descriptor's destination port mask: bit n selects port n, and all ones means every port.
- R8: tx_done_flag is set when the engine, with at least one frame sent since the last start, finds the current entry not ready. It is cleared when a frame starts or when done_clr is pulsed. A set wins over a clear in the same cycle.
- R9: If sink_err is 1 on a data beat, the engine ends the frame and pulses desc_wb_en with desc_wb_err=1, and the entry stays ready. tx_err_flag is set and desc_idx does not move. After err_clr, the same entry is sent again from its start.
- R10: While tx_en is 0, any frame in progress is dropped without writeback, and desc_idx is 0 on the next cycle.
- R11: Each successful frame sets a sent-pending bit and each fault sets a fault-pending bit. An acknowledge pulse clears the bit, and a set wins over an acknowledge in the same cycle. irq_tx_done and irq_tx_err show their pending bit unless the matching mask input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Engine enable; low returns the index to 0 |
| desc_idx | output | 3 | Index of the descriptor being handled |
| desc_ready | input | 1 | Ready bit of the selected descriptor |
| desc_ts_en | input | 1 | Timestamp tag request of the selected descriptor |
| desc_pad_en | input | 1 | Pad request of the selected descriptor |
| desc_fid | input | 16 | Frame identifier of the selected descriptor |
| desc_offset | input | 16 | Byte offset in packet RAM, 32-bit aligned |
| desc_len | input | 16 | Frame length in bytes, even |
| desc_pmask | input | 32 | Destination port mask |
| desc_wb_en | output | 1 | Writeback strobe for entry desc_idx |
| desc_wb_err | output | 1 | 1: set error and keep ready; 0: clear ready |
| ram_addr | output | 14 | Packet RAM word address |
| ram_rdata | input | 32 | Packet RAM read data for ram_addr |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 16 | Stream beat data |
| out_last | output | 1 | Last beat of the frame |
| out_oob | output | 1 | Beat is the out-of-band tag |
| out_pmask | output | 32 | Port mask of the frame in flight |
| sink_err | input | 1 | Sink reports an error on the current beat |
| tx_done_flag | output | 1 | All handed-over descriptors sent |
| done_clr | input | 1 | Clears tx_done_flag |
| tx_err_flag | output | 1 | Transmission halted on a fault |
| err_clr | input | 1 | Clears tx_err_flag and resumes |
| irq_tx_done | output | 1 | Frame-sent interrupt, level |
| irq_tx_done_ack | input | 1 | Acknowledge for frame-sent pending bit |
| irq_tx_done_mask | input | 1 | Masks irq_tx_done |
| irq_tx_err | output | 1 | Fault interrupt, level |
| irq_tx_err_ack | input | 1 | Acknowledge for fault pending bit |
| irq_tx_err_mask | input | 1 | Masks irq_tx_err |

## Verification
The first frames run with the sink always ready and mix a plain frame, a short padded frame with a tag, and a frame long enough that padding does not apply. Together they separate the data path, the zero fill and the tag beat. A second run applies pseudo-random backpressure across a batch that wraps the index from 7 to 0, which exposes beats that change while stalled and pointer-wrap mistakes. A sink error injected mid-frame shows whether the engine halts, keeps the index and resends from byte zero, with the interrupt masks toggled so that pending bits and masked outputs can be told apart. Dropping the enable in the middle of a long frame checks that the frame is discarded and the index returns to 0.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [1:0] {
    ST_SCAN = 2'd0,
    ST_DATA = 2'd1,
    ST_TAG  = 2'd2
  } txr_state_e;

  localparam int unsigned MIN_FRAME_BYTES = 60;
  localparam int unsigned BEAT_BYTES      = 2;
endpackage

// File: rtl/txr_sequencer.sv
module txr_sequencer
  import txr_pkg::*;
#(
  parameter int unsigned NDESC  = 8,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned FID_W  = 16,
  parameter int unsigned MASK_W = 32,
  localparam int unsigned IDX_W = $clog2(NDESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              d_ready,
  input  logic              d_ts,
  input  logic              d_pad,
  input  logic [FID_W-1:0]  d_fid,
  input  logic [LEN_W-1:0]  d_off,
  input  logic [LEN_W-1:0]  d_len,
  input  logic [MASK_W-1:0] d_pmask,
  input  logic              out_ready,
  input  logic              sink_err,
  input  logic              err_flag,
  input  logic              data_end,
  output txr_state_e        state_o,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [LEN_W-1:0]  cnt_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [LEN_W-1:0]  elen_o,
  output logic [LEN_W-1:0]  off_o,
  output logic [FID_W-1:0]  fid_o,
  output logic              ts_o,
  output logic [MASK_W-1:0] pmask_o,
  output logic              ev_start,
  output logic              ev_drained,
  output logic              ev_complete,
  output logic              ev_fault
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME_BYTES);
  localparam logic [LEN_W-1:0] STEP    = LEN_W'(BEAT_BYTES);

  txr_state_e        st_q, st_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d, ptr_inc;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              sent_q, sent_d;
  logic [LEN_W-1:0]  len_q, elen_q, off_q;
  logic [FID_W-1:0]  fid_q;
  logic              ts_q;
  logic [MASK_W-1:0] pmask_q;
  logic              hs, final_beat;

  assign ptr_inc = (ptr_q == IDX_W'(NDESC - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    hs          = ((st_q == ST_DATA) || (st_q == ST_TAG)) && out_ready;
    ev_fault    = tx_en && (st_q == ST_DATA) && sink_err;
    final_beat  = (st_q == ST_TAG) || ((st_q == ST_DATA) && data_end && !ts_q);
    ev_complete = tx_en && hs && !ev_fault && final_beat;
    ev_start    = tx_en && (st_q == ST_SCAN) && !err_flag && d_ready;
    ev_drained  = tx_en && (st_q == ST_SCAN) && !err_flag && !d_ready && sent_q;
  end

  // next-state process
  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (!tx_en) begin
      st_d  = ST_SCAN;
      ptr_d = '0;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_SCAN: if (ev_start) begin
          st_d  = ST_DATA;
          cnt_d = '0;
        end
        ST_DATA: begin
          if (ev_fault) st_d = ST_SCAN;
          else if (hs) begin
            if (data_end) st_d = ts_q ? ST_TAG : ST_SCAN;
            else cnt_d = cnt_q + STEP;
          end
        end
        ST_TAG: if (hs) st_d = ST_SCAN;
        default: st_d = ST_SCAN;
      endcase
      if (ev_complete) ptr_d = ptr_inc;
    end
    sent_d = sent_q;
    if (ev_start || ev_drained) sent_d = 1'b0;
    if (ev_complete)            sent_d = 1'b1;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SCAN;
      ptr_q  <= '0;
      cnt_q  <= '0;
      sent_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      sent_q <= sent_d;
    end
  end

  // descriptor copy, loaded when a frame starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      elen_q  <= '0;
      off_q   <= '0;
      fid_q   <= '0;
      ts_q    <= 1'b0;
      pmask_q <= '0;
    end else if (ev_start) begin
      len_q   <= d_len;
      elen_q  <= (d_pad && (d_len < MIN_LEN)) ? MIN_LEN : d_len;
      off_q   <= d_off;
      fid_q   <= d_fid;
      ts_q    <= d_ts;
      pmask_q <= d_pmask;
    end
  end

  // a tag beat is only ever entered from a tagged frame (R6)
  assert_tag_needs_ts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAG) |-> ts_q);

  assign state_o = st_q;
  assign ptr_o   = ptr_q;
  assign cnt_o   = cnt_q;
  assign len_o   = len_q;
  assign elen_o  = elen_q;
  assign off_o   = off_q;
  assign fid_o   = fid_q;
  assign ts_o    = ts_q;
  assign pmask_o = pmask_q;
endmodule

// File: rtl/txr_beat_gen.sv
module txr_beat_gen
  import txr_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned FID_W = 16,
  localparam int unsigned DATA_W = 16,
  localparam int unsigned RAM_W  = 2 * DATA_W,
  localparam int unsigned RAM_AW = LEN_W - 2
) (
  input  txr_state_e         state,
  input  logic [LEN_W-1:0]   cnt,
  input  logic [LEN_W-1:0]   len,
  input  logic [LEN_W-1:0]   elen,
  input  logic [LEN_W-1:0]   off,
  input  logic [FID_W-1:0]   fid,
  input  logic               ts,
  input  logic [RAM_W-1:0]   ram_rdata,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_last,
  output logic               out_oob,
  output logic               data_end
);
  logic [LEN_W-1:0]  baddr;
  logic [DATA_W-1:0] half;

  always_comb begin
    baddr     = off + cnt;
    ram_addr  = baddr[LEN_W-1:2];
    half      = baddr[1] ? ram_rdata[RAM_W-1:DATA_W] : ram_rdata[DATA_W-1:0];
    data_end  = (cnt == (elen - LEN_W'(BEAT_BYTES)));
    out_valid = (state == ST_DATA) || (state == ST_TAG);
    out_oob   = (state == ST_TAG);
    out_last  = out_oob || ((state == ST_DATA) && data_end && !ts);
    if (out_oob)          out_data = DATA_W'(fid);
    else if (cnt >= len)  out_data = '0;
    else                  out_data = half;
  end
endmodule

// File: rtl/txr_status.sv
module txr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic clr_done,
  input  logic set_err,
  input  logic clr_err,
  input  logic set_tc,
  input  logic ack_tc,
  input  logic set_te,
  input  logic ack_te,
  input  logic mask_tc,
  input  logic mask_te,
  output logic done_flag,
  output logic err_flag,
  output logic irq_tc,
  output logic irq_te
);
  localparam int unsigned NFLAG = 4;

  logic [NFLAG-1:0] set_v, clr_v, flag_q;

  assign set_v = {set_te, set_tc, set_err, set_done};
  assign clr_v = {ack_te, ack_tc, clr_err, clr_done};

  // one sticky cell per flag, set has priority over clear
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic nxt;
    always_comb begin
      nxt = flag_q[g];
      if (clr_v[g]) nxt = 1'b0;
      if (set_v[g]) nxt = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= nxt;
    end
  end

  assign done_flag = flag_q[0];
  assign err_flag  = flag_q[1];
  assign irq_tc    = flag_q[2] & ~mask_tc;
  assign irq_te    = flag_q[3] & ~mask_te;

  // a set always lands even with a simultaneous clear (R8, R11)
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_te |=> flag_q[3]);
  assert_done_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> done_flag);
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import txr_pkg::*;
#(
  parameter int unsigned NDESC  = 8,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned FID_W  = 16,
  parameter int unsigned MASK_W = 32,
  localparam int unsigned IDX_W  = $clog2(NDESC),
  localparam int unsigned RAM_AW = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  output logic [IDX_W-1:0]  desc_idx,
  input  logic              desc_ready,
  input  logic              desc_ts_en,
  input  logic              desc_pad_en,
  input  logic [FID_W-1:0]  desc_fid,
  input  logic [LEN_W-1:0]  desc_offset,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic [MASK_W-1:0] desc_pmask,
  output logic              desc_wb_en,
  output logic              desc_wb_err,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic [31:0]       ram_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_data,
  output logic              out_last,
  output logic              out_oob,
  output logic [MASK_W-1:0] out_pmask,
  input  logic              sink_err,
  output logic              tx_done_flag,
  input  logic              done_clr,
  output logic              tx_err_flag,
  input  logic              err_clr,
  output logic              irq_tx_done,
  input  logic              irq_tx_done_ack,
  input  logic              irq_tx_done_mask,
  output logic              irq_tx_err,
  input  logic              irq_tx_err_ack,
  input  logic              irq_tx_err_mask
);
  logic [1:0]        rst_sync_q;
  logic              rst_sn;
  txr_state_e        st;
  logic [LEN_W-1:0]  cnt, len, elen, off;
  logic [FID_W-1:0]  fid;
  logic              ts, data_end;
  logic              ev_start, ev_drained, ev_complete, ev_fault;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  txr_sequencer #(.NDESC(NDESC), .LEN_W(LEN_W), .FID_W(FID_W), .MASK_W(MASK_W)) u_seq (
    .clk(clk), .rst_n(rst_sn), .tx_en(tx_en),
    .d_ready(desc_ready), .d_ts(desc_ts_en), .d_pad(desc_pad_en), .d_fid(desc_fid),
    .d_off(desc_offset), .d_len(desc_len), .d_pmask(desc_pmask),
    .out_ready(out_ready), .sink_err(sink_err), .err_flag(tx_err_flag), .data_end(data_end),
    .state_o(st), .ptr_o(desc_idx), .cnt_o(cnt), .len_o(len), .elen_o(elen), .off_o(off),
    .fid_o(fid), .ts_o(ts), .pmask_o(out_pmask),
    .ev_start(ev_start), .ev_drained(ev_drained), .ev_complete(ev_complete), .ev_fault(ev_fault)
  );

  txr_beat_gen #(.LEN_W(LEN_W), .FID_W(FID_W)) u_beat (
    .state(st), .cnt(cnt), .len(len), .elen(elen), .off(off), .fid(fid), .ts(ts),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_oob(out_oob), .data_end(data_end)
  );

  txr_status u_stat (
    .clk(clk), .rst_n(rst_sn),
    .set_done(ev_drained), .clr_done(done_clr | ev_start),
    .set_err(ev_fault), .clr_err(err_clr),
    .set_tc(ev_complete), .ack_tc(irq_tx_done_ack),
    .set_te(ev_fault), .ack_te(irq_tx_err_ack),
    .mask_tc(irq_tx_done_mask), .mask_te(irq_tx_err_mask),
    .done_flag(tx_done_flag), .err_flag(tx_err_flag),
    .irq_tc(irq_tx_done), .irq_te(irq_tx_err)
  );

  assign desc_wb_en  = ev_complete | ev_fault;
  assign desc_wb_err = ev_fault;

  assert_wb_in_beat_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    desc_wb_en |-> out_valid);
  assert_ptr_adv_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (desc_wb_en && !desc_wb_err && tx_en) |=> (desc_idx == IDX_W'(($past(desc_idx) + 1) % NDESC)));
  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (desc_wb_en && desc_wb_err) |=> ($stable(desc_idx) && tx_err_flag && !out_valid));
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ready && tx_en && !sink_err) |=> (out_valid && $stable(out_data)));
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !tx_en |=> (desc_idx == '0 && !out_valid));
  assert_oob_last_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    out_oob |-> (out_last && out_valid));
endmodule

// File: tb/tb_tx_desc_ring.sv
`timescale 1ns/1ps
module tb_tx_desc_ring;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tx_en, out_ready, sink_err, done_clr, err_clr;
  logic tc_ack, tc_mask, te_ack, te_mask;
  logic [2:0]  desc_idx;
  logic        desc_ready, desc_ts_en, desc_pad_en, desc_wb_en, desc_wb_err;
  logic [15:0] desc_fid, desc_offset, desc_len;
  logic [31:0] desc_pmask, ram_rdata, out_pmask;
  logic [13:0] ram_addr;
  logic        out_valid, out_last, out_oob, tx_done_flag, tx_err_flag, irq_tx_done, irq_tx_err;
  logic [15:0] out_data;

  logic        t_rdy[8], t_ts[8], t_pad[8];
  logic [15:0] t_fid[8], t_off[8], t_len[8];
  logic [31:0] t_pm[8];
  logic [31:0] pram[256];

  assign desc_ready  = t_rdy[desc_idx];
  assign desc_ts_en  = t_ts[desc_idx];
  assign desc_pad_en = t_pad[desc_idx];
  assign desc_fid    = t_fid[desc_idx];
  assign desc_offset = t_off[desc_idx];
  assign desc_len    = t_len[desc_idx];
  assign desc_pmask  = t_pm[desc_idx];
  assign ram_rdata   = pram[ram_addr[7:0]];

  tx_desc_ring dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .desc_idx(desc_idx),
    .desc_ready(desc_ready), .desc_ts_en(desc_ts_en), .desc_pad_en(desc_pad_en),
    .desc_fid(desc_fid), .desc_offset(desc_offset), .desc_len(desc_len), .desc_pmask(desc_pmask),
    .desc_wb_en(desc_wb_en), .desc_wb_err(desc_wb_err), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_oob(out_oob), .out_pmask(out_pmask), .sink_err(sink_err),
    .tx_done_flag(tx_done_flag), .done_clr(done_clr), .tx_err_flag(tx_err_flag), .err_clr(err_clr),
    .irq_tx_done(irq_tx_done), .irq_tx_done_ack(tc_ack), .irq_tx_done_mask(tc_mask),
    .irq_tx_err(irq_tx_err), .irq_tx_err_ack(te_ack), .irq_tx_err_mask(te_mask)
  );

  int n_cmp = 0, n_bad = 0, n_cyc = 0;
  bit in_reset, rnd_mode, en_prev;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural model state: 0 idle/scan, 1 data, 2 tag
  int ms, mptr, mcnt, mlen, melen, moff, msent;
  bit mts, mdone, merr, mtc, mte;
  logic [15:0] mfid;
  logic [31:0] mpm;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  task automatic cyc();
    bit v, hs, lastd, fault, fin, start, drained;
    int a;
    logic [31:0] w;
    logic [15:0] ed;
    string rq;
    if (rnd_mode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
    end else out_ready = 1'b1;
    #1;
    // expected outputs from model state and current inputs
    v     = (ms == 1) || (ms == 2);
    hs    = v && out_ready;
    lastd = (ms == 1) && (mcnt == melen - 2);
    fault = tx_en && (ms == 1) && sink_err;
    fin   = tx_en && hs && !fault && ((ms == 2) || (lastd && !mts));
    a     = (moff + mcnt) & 16'hFFFF;
    w     = pram[(a >> 2) & 255];
    if (ms == 2)          begin ed = mfid; rq = "R6"; end
    else if (mcnt >= mlen) begin ed = '0; rq = "R5"; end
    else                   begin ed = ((a >> 1) & 1) ? w[31:16] : w[15:0]; rq = "R3"; end
    if (in_reset) begin
      chk(out_valid, 0, "R1", "out_valid");
      chk(desc_idx, 0, "R1", "desc_idx");
      chk(tx_done_flag, 0, "R1", "done");
      chk(tx_err_flag, 0, "R1", "err");
      chk(irq_tx_done | irq_tx_err, 0, "R1", "irq");
      chk(desc_wb_en, 0, "R1", "wb_en");
    end else begin
      chk(out_valid, v, "R3", "out_valid");
      chk(out_oob, ms == 2, "R6", "out_oob");
      if (v) begin
        chk(out_data, ed, rq, "out_data");
        chk(out_last, (ms == 2) || (lastd && !mts), "R6", "out_last");
        chk(out_pmask, mpm, "R7", "out_pmask");
      end
      chk(desc_idx, mptr, en_prev ? "R2" : "R10", "desc_idx");
      chk(desc_wb_en, fin || fault, fault ? "R9" : "R4", "wb_en");
      if (fin || fault) chk(desc_wb_err, fault, "R9", "wb_err");
      chk(tx_done_flag, mdone, "R8", "done_flag");
      chk(tx_err_flag, merr, "R9", "err_flag");
      chk(irq_tx_done, mtc && !tc_mask, "R11", "irq_tx_done");
      chk(irq_tx_err, mte && !te_mask, "R11", "irq_tx_err");
    end
    // model next state
    start   = tx_en && (ms == 0) && !merr && t_rdy[mptr];
    drained = tx_en && (ms == 0) && !merr && !t_rdy[mptr] && (msent != 0);
    if (fin) t_rdy[mptr] = 1'b0;
    if (!tx_en) begin
      ms = 0; mptr = 0; mcnt = 0;
    end else begin
      if (ms == 0) begin
        if (start) begin
          ms = 1; mcnt = 0; mlen = t_len[mptr]; moff = t_off[mptr]; mfid = t_fid[mptr];
          mts = t_ts[mptr]; mpm = t_pm[mptr];
          melen = (t_pad[mptr] && t_len[mptr] < 60) ? 60 : t_len[mptr];
        end
      end else if (ms == 1) begin
        if (fault) ms = 0;
        else if (hs) begin
          if (lastd) ms = mts ? 2 : 0;
          else mcnt += 2;
        end
      end else if (hs) ms = 0;
      if (fin) mptr = (mptr + 1) % 8;
    end
    if (start || drained) msent = 0;
    if (fin) msent = 1;
    if (start || done_clr) mdone = 0;
    if (drained) mdone = 1;
    if (err_clr) merr = 0;
    if (fault) merr = 1;
    if (tc_ack) mtc = 0;
    if (fin) mtc = 1;
    if (te_ack) mte = 0;
    if (fault) mte = 1;
    en_prev = tx_en;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic set_desc(input int i, input int off, input int len, input bit pad, input bit ts,
                          input logic [15:0] fid, input logic [31:0] pm);
    t_off[i] = 16'(off); t_len[i] = 16'(len); t_pad[i] = pad; t_ts[i] = ts;
    t_fid[i] = fid; t_pm[i] = pm; t_rdy[i] = 1'b1;
  endtask

  initial begin
    rst_n = 0; tx_en = 0; out_ready = 1; sink_err = 0; done_clr = 0; err_clr = 0;
    tc_ack = 0; tc_mask = 0; te_ack = 0; te_mask = 0; rnd_mode = 0; en_prev = 0;
    ms = 0; mptr = 0; mcnt = 0; mlen = 0; melen = 0; moff = 0; msent = 0;
    mts = 0; mdone = 0; merr = 0; mtc = 0; mte = 0; mfid = '0; mpm = '0;
    for (int i = 0; i < 256; i++) pram[i] = 32'(i + 1) * 32'h9E3779B1;
    for (int i = 0; i < 8; i++) begin
      t_rdy[i] = 0; t_ts[i] = 0; t_pad[i] = 0; t_fid[i] = '0; t_off[i] = '0; t_len[i] = 16'd2; t_pm[i] = '0;
    end
    @(negedge clk);
    // R1: reset state, held and just after release
    in_reset = 1;
    run(3);
    rst_n = 1;
    run(3);
    in_reset = 0;
    run(2);

    // R3 R5 R6 R7: plain, short padded with tag, long padded
    set_desc(0, 0, 8, 0, 0, 16'h0000, 32'h0000_0001);
    set_desc(1, 16, 10, 1, 1, 16'hBEEF, 32'hFFFF_FFFF);
    set_desc(2, 64, 64, 1, 0, 16'h0000, 32'h0000_0004);
    tx_en = 1;
    run(120);
    // R8 R11: clears
    done_clr = 1; tc_ack = 1; run(1); done_clr = 0; tc_ack = 0;
    run(3);

    // R2: wrap 7 -> 0 under random backpressure
    set_desc(3, 200, 6, 0, 1, 16'h1234, 32'h0000_0008);
    set_desc(4, 300, 58, 1, 0, 16'h0000, 32'h0000_0010);
    set_desc(5, 400, 60, 1, 0, 16'h0000, 32'h0000_0020);
    set_desc(6, 500, 2, 0, 0, 16'h0000, 32'h0000_0040);
    set_desc(7, 520, 12, 0, 1, 16'h5A5A, 32'h0000_0080);
    set_desc(0, 600, 4, 0, 0, 16'h0000, 32'h8000_0000);
    rnd_mode = 1;
    run(500);
    rnd_mode = 0;
    tc_ack = 1; done_clr = 1; run(1); tc_ack = 0; done_clr = 0;

    // R9: sink error mid-frame, resend after clear; R11 masks
    tc_mask = 1;
    set_desc(1, 40, 20, 0, 0, 16'h0000, 32'h0000_0002);
    for (int k = 0; k < 100 && !(ms == 1 && mcnt == 4 && mptr == 1); k++) cyc();
    sink_err = 1; run(1); sink_err = 0;
    run(10);
    err_clr = 1; run(1); err_clr = 0;
    run(60);
    te_ack = 1; run(1); te_ack = 0;
    te_mask = 1;
    set_desc(2, 80, 30, 0, 1, 16'h7777, 32'h0000_0100);
    for (int k = 0; k < 100 && !(ms == 1 && mcnt == 6 && mptr == 2); k++) cyc();
    sink_err = 1; run(1); sink_err = 0;
    run(5);
    te_mask = 0; run(2);
    err_clr = 1; te_ack = 1; run(1); err_clr = 0; te_ack = 0;
    tc_mask = 0;
    run(60);

    // R10: drop enable mid-frame
    set_desc(3, 100, 200, 0, 0, 16'h0000, 32'h0000_0200);
    set_desc(0, 8, 4, 0, 1, 16'hC0DE, 32'h0000_0400);
    for (int k = 0; k < 200 && !(ms == 1 && mcnt == 20); k++) cyc();
    tx_en = 0; run(3); tx_en = 1;
    run(200);

    summary();
    $finish;
  end
endmodule